// File: doc/BRIEF.md
# Synchronous Serial Port with Auto-Transfer Buffer

This block is a three-wire synchronous serial port (clock, data in, data out) for one byte-wide channel. It exchanges bytes through a small on-chip buffer of eight byte slots. Software first fills the slots, then gives a byte count and pulses start. The port then shifts that many bytes back to back with no software service between bytes. As each byte finishes, the byte received during it overwrites the slot its outgoing byte came from. The port raises a done flag when the programmed count has been reached.

The serial clock can come from a divider inside the block (master) or from the clock pin (slave). In slave operation the external clock, the data input and the chip select pass through two-flop synchronizers, and their edges are detected in the system clock domain. An optional chip-select mode gates the port with an active-low select input:

- While the port is deselected, the data output enable is low, and so is the clock output enable in master operation.
- Pulling select high in the middle of a byte abandons the transfer. The bytes already completed are kept and an error flag is raised.

Top module: `sio_autoxfer`

## Requirements
- R1: After reset, busy, done and abort_err are 0 and sck_out is 1. With cs_mode=0 and master=1, so_oe and sck_oe are both 1.
- R2: A start while idle transfers exactly xfer_len_m1+1 bytes, using slots 0 up to xfer_len_m1. The port then sets done=1 and busy=0 in the same cycle. Slots beyond the count keep their contents, and done and busy are never 1 together.
- R3: Each byte is shifted most significant bit first on so. While a transfer runs in master mode, so changes only in the cycle in which sck_out has just fallen.
- R4: The byte received during a byte slot is {first sampled bit, ..., last sampled bit}, most significant bit first. It is written back into that same slot once its 8th bit has been sampled.
- R5: In master mode the serial clock has a period of CLK_DIV system clocks (default 16), with each half lasting CLK_DIV/2 clocks. The clock idles high, and sck_out is 1 in every cycle that follows an idle cycle.
- R6: In slave mode (master=0), the port samples si on the rising edges of sck_in and advances so on its falling edges, both seen after two-flop synchronization. sck_oe stays 0 in this mode.
- R7: With cs_mode=1, so_oe is 1 only while the synchronized cs_n is low. After cs_n has been high for three clocks, so_oe is 0 (and so is sck_oe). With cs_mode=0, so_oe is 1.
- R8: With cs_mode=1, raising cs_n after 1 to 7 bits of a byte have been sampled ends the transfer. The port sets abort_err=1, busy=0 and done=0. Completed bytes stay written back, and the partial byte's slot is left unchanged.
- R9: A start pulse while busy is ignored, and the byte count is captured at the accepted start. done stays 1 until the next accepted start, which clears it.
- R10: Every accepted start begins from slot 0, whatever count the previous transfer used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Write strobe for a buffer slot |
| host_waddr | input | 3 | Slot written by host_we |
| host_wdata | input | 8 | Byte written by host_we |
| host_raddr | input | 3 | Slot shown on host_rdata |
| host_rdata | output | 8 | Contents of slot host_raddr |
| xfer_len_m1 | input | 3 | Byte count minus one, captured at start |
| start | input | 1 | Start pulse, accepted while idle |
| master | input | 1 | 1 = internal clock, 0 = external clock |
| cs_mode | input | 1 | 1 = gate the port with cs_n |
| sck_in | input | 1 | External serial clock |
| si | input | 1 | Serial data input |
| cs_n | input | 1 | Active-low chip select |
| sck_out | output | 1 | Generated serial clock |
| sck_oe | output | 1 | Output enable for sck_out |
| so | output | 1 | Serial data output |
| so_oe | output | 1 | Output enable for so |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Programmed count completed |
| abort_err | output | 1 | Transfer abandoned by deselect |

## Verification
The bench builds the port with its defaults: 8-bit bytes, eight slots and a divide-by-16 clock. An eight-byte run therefore wraps the slot pointer, and a one-byte run exercises the shortest count. The 16-cycle divider makes the period and the falling-edge-only output changes directly measurable. A slave clock of ten system cycles leaves enough margin for the three-stage synchronizer-and-edge path. Aborting after eleven bits checks the keep-completed-bytes rule across a byte boundary.

// File: rtl/sio_pkg.sv
package sio_pkg;
  // Half period of the serial clock, in system clocks
  function automatic int unsigned half_period(int unsigned div);
    return (div < 4) ? 1 : div / 2;
  endfunction

  // Counter width that can hold values 0..n-1 (at least 1 bit)
  function automatic int unsigned cnt_width(int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // Append a sampled bit at the least significant end (MSB-first order)
  function automatic logic [7:0] shift_in(logic [7:0] r, logic b);
    return {r[6:0], b};
  endfunction
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] level,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '1;
      s2 <= '1;
      s3 <= '1;
    end else begin
      s1 <= async_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign level = s2;
  assign rise  = s2 & ~s3;
  assign fall  = ~s2 & s3;
endmodule

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
  parameter int CLK_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int HALF = sio_pkg::half_period(CLK_DIV);
  localparam int CW   = sio_pkg::cnt_width(HALF);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick     = run && (cnt == CW'(HALF - 1));
  assign fall_evt = tick && sck;
  assign rise_evt = tick && !sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b1;
    end else if (!run) begin
      cnt <= '0;
      sck <= 1'b1;
    end else if (tick) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sio_slots.sv
module sio_slots #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int PW   = sio_pkg::cnt_width(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [PW-1:0] host_waddr,
  input  logic [W-1:0]  host_wdata,
  input  logic [PW-1:0] host_raddr,
  output logic [W-1:0]  host_rdata,
  input  logic          eng_we,
  input  logic [PW-1:0] eng_addr,
  input  logic [W-1:0]  eng_wdata,
  output logic [W-1:0]  eng_rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (eng_we) begin
      mem[eng_addr] <= eng_wdata;
    end else if (host_we) begin
      mem[host_waddr] <= host_wdata;
    end
  end

  assign host_rdata = mem[host_raddr];
  assign eng_rdata  = mem[eng_addr];
endmodule

// File: rtl/sio_autoxfer.sv
module sio_autoxfer #(
  parameter int W       = 8,
  parameter int DEPTH   = 8,
  parameter int CLK_DIV = 16,
  localparam int PW     = sio_pkg::cnt_width(DEPTH),
  localparam int BW     = sio_pkg::cnt_width(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [PW-1:0] host_waddr,
  input  logic [W-1:0]  host_wdata,
  input  logic [PW-1:0] host_raddr,
  output logic [W-1:0]  host_rdata,
  input  logic [PW-1:0] xfer_len_m1,
  input  logic          start,
  input  logic          master,
  input  logic          cs_mode,
  input  logic          sck_in,
  input  logic          si,
  input  logic          cs_n,
  output logic          sck_out,
  output logic          sck_oe,
  output logic          so,
  output logic          so_oe,
  output logic          busy,
  output logic          done,
  output logic          abort_err
);
  // Synchronized pins: bit 2 = sck_in, bit 1 = cs_n, bit 0 = si
  logic [2:0] sy_lvl, sy_rise, sy_fall;
  sio_sync #(.N(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in({sck_in, cs_n, si}),
    .level(sy_lvl), .rise(sy_rise), .fall(sy_fall)
  );

  logic cs_sel, enabled;
  assign cs_sel  = !sy_lvl[1];
  assign enabled = !cs_mode || cs_sel;

  logic m_rise, m_fall;
  sio_clkgen #(.CLK_DIV(CLK_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy && master && enabled),
    .sck(sck_out), .rise_evt(m_rise), .fall_evt(m_fall)
  );

  // Named internal events
  logic rise_e, fall_e, abort_e, byte_end, si_bit;
  assign rise_e   = enabled && (master ? m_rise : sy_rise[2]);
  assign fall_e   = enabled && (master ? m_fall : sy_fall[2]);
  assign si_bit   = master ? si : sy_lvl[0];

  logic [PW-1:0] ptr, len_q;
  logic [BW-1:0] bit_cnt;
  logic [W-1:0]  txreg, rxreg, eng_rdata;

  assign abort_e  = busy && cs_mode && sy_rise[1] && (bit_cnt != '0);
  assign byte_end = busy && rise_e && !abort_e && (bit_cnt == BW'(W - 1));

  sio_slots #(.W(W), .DEPTH(DEPTH)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we && !busy), .host_waddr(host_waddr), .host_wdata(host_wdata),
    .host_raddr(host_raddr), .host_rdata(host_rdata),
    .eng_we(byte_end), .eng_addr(busy ? ptr : '0),
    .eng_wdata(sio_pkg::shift_in(rxreg, si_bit)), .eng_rdata(eng_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      abort_err <= 1'b0;
      ptr       <= '0;
      len_q     <= '0;
      bit_cnt   <= '0;
      txreg     <= '0;
      rxreg     <= '0;
    end else if (!busy) begin
      if (start) begin
        busy      <= 1'b1;
        done      <= 1'b0;
        abort_err <= 1'b0;
        ptr       <= '0;
        len_q     <= xfer_len_m1;
        bit_cnt   <= '0;
        txreg     <= eng_rdata;
      end
    end else if (abort_e) begin
      busy      <= 1'b0;
      abort_err <= 1'b1;
      bit_cnt   <= '0;
    end else if (fall_e) begin
      txreg <= (bit_cnt == '0) ? eng_rdata : {txreg[W-2:0], 1'b0};
    end else if (rise_e) begin
      rxreg <= sio_pkg::shift_in(rxreg, si_bit);
      if (byte_end) begin
        bit_cnt <= '0;
        ptr     <= ptr + 1'b1;
        if (ptr == len_q) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign so     = txreg[W-1];
  assign so_oe  = enabled;
  assign sck_oe = master && enabled;
endmodule

// File: rtl/sio_autoxfer_chk.sv
module sio_autoxfer_chk (
  input logic clk,
  input logic rst_n,
  input logic master,
  input logic cs_mode,
  input logic cs_n,
  input logic sck_out,
  input logic sck_oe,
  input logic so,
  input logic so_oe,
  input logic busy,
  input logic done,
  input logic abort_err
);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_so_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (master && busy && $past(busy) && !$stable(so)) |-> (!sck_out && $past(sck_out)));

  assert_sck_idle_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> sck_out);

  assert_deselect_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_mode && cs_n && $past(cs_n) && $past(cs_n, 2)) |-> (!so_oe && !sck_oe));

  assert_abort_not_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_err |-> !done);
endmodule

bind sio_autoxfer sio_autoxfer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .master(master), .cs_mode(cs_mode), .cs_n(cs_n),
  .sck_out(sck_out), .sck_oe(sck_oe), .so(so), .so_oe(so_oe),
  .busy(busy), .done(done), .abort_err(abort_err)
);

// File: tb/tb_sio_autoxfer.sv
`timescale 1ns/1ps
module tb_sio_autoxfer;
  localparam int DIV = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_we = 1'b0;
  logic [2:0] host_waddr = '0;
  logic [7:0] host_wdata = '0;
  logic [2:0] host_raddr = '0;
  logic [7:0] host_rdata;
  logic [2:0] xfer_len_m1 = '0;
  logic       start = 1'b0, master = 1'b1, cs_mode = 1'b0;
  logic       sck_in = 1'b1, si = 1'b0, cs_n = 1'b1;
  logic       sck_out, sck_oe, so, so_oe, busy, done, abort_err;

  int nvec = 0;
  int nfail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sio_autoxfer dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_waddr(host_waddr),
    .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
    .xfer_len_m1(xfer_len_m1), .start(start), .master(master), .cs_mode(cs_mode),
    .sck_in(sck_in), .si(si), .cs_n(cs_n), .sck_out(sck_out), .sck_oe(sck_oe),
    .so(so), .so_oe(so_oe), .busy(busy), .done(done), .abort_err(abort_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_slot(input int i, input logic [7:0] v);
    @(negedge clk);
    host_we = 1'b1; host_waddr = 3'(i); host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic get_slot(input int i, output logic [7:0] v);
    @(negedge clk);
    host_raddr = 3'(i);
    #1 v = host_rdata;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // R1: reset state
  task automatic t_reset();
    master = 1'b1; cs_mode = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 abort_err", abort_err, 0);
    chk("R1 sck_out", sck_out, 1);
    chk("R1 so_oe", so_oe, 1);
    chk("R1 sck_oe", sck_oe, 1);
  endtask

  // Master-mode run; the bench acts as the remote slave
  task automatic t_master(input int nb, input logic [7:0] seed, input bit midstart);
    logic [7:0] mtx [8];
    logic [7:0] stx [8];
    logic [7:0] got [8];
    logic [7:0] cap, v;
    int bitidx, bidx, cyc, last_fall, nfall;
    logic prev;
    master = 1'b1; cs_mode = 1'b0;
    for (int i = 0; i < 8; i++) begin
      mtx[i] = seed ^ 8'(i * 37 + 11);
      stx[i] = ~mtx[i] + 8'(i);
      put_slot(i, mtx[i]);
    end
    xfer_len_m1 = 3'(nb - 1);
    si = stx[0][7];
    bitidx = 0; bidx = 0; cyc = 0; nfall = 0; last_fall = 0; cap = '0;
    pulse_start();
    chk("R9 done cleared by start", done, 0);
    chk("R2 busy after start", busy, 1);
    prev = sck_out;
    while (cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (midstart && cyc == 40) begin xfer_len_m1 = 3'd7; start = 1'b1; end
      if (midstart && cyc == 41) start = 1'b0;
      if (!prev && sck_out) begin
        cap = {cap[6:0], so};
        bitidx++;
        if (bitidx == 8) begin
          if (bidx < 8) got[bidx] = cap;
          bidx++;
          bitidx = 0;
        end
      end
      if (prev && !sck_out) begin
        nfall++;
        if (nfall == 2) chk("R5 serial clock period", 32'(cyc - last_fall), DIV);
        last_fall = cyc;
        if (bidx < 8) si = stx[bidx][7 - bitidx];
      end
      prev = sck_out;
      if (!busy) break;
    end
    chk(midstart ? "R9 count latched, restart ignored" : "R2 byte count", 32'(bidx), 32'(nb));
    chk("R2 done set", done, 1);
    chk("R2 busy clear", busy, 0);
    for (int i = 0; i < nb && i < 8; i++)
      chk("R3 MSB-first byte on so (R10 from slot 0)", got[i], mtx[i]);
    for (int i = 0; i < 8; i++) begin
      get_slot(i, v);
      if (i < nb) chk("R4 received byte in own slot", v, stx[i]);
      else        chk("R2 slot beyond count untouched", v, mtx[i]);
    end
    repeat (10) @(negedge clk);
    chk("R9 done holds", done, 1);
    chk("R5 idle clock high", sck_out, 1);
  endtask

  // Slave-clock run in chip-select mode, optional abort after abort_bits bits
  task automatic t_slave(input int nb, input logic [7:0] seed, input int abort_bits);
    logic [7:0] mtx [8];
    logic [7:0] stx [8];
    logic [7:0] got [8];
    logic [7:0] cap, v;
    int total;
    master = 1'b0; cs_mode = 1'b1; cs_n = 1'b1; sck_in = 1'b1;
    for (int i = 0; i < 8; i++) begin
      mtx[i] = seed + 8'(i * 29);
      stx[i] = mtx[i] ^ 8'hC3;
      put_slot(i, mtx[i]);
    end
    repeat (4) @(negedge clk);
    chk("R7 so_oe floats while deselected", so_oe, 0);
    chk("R6 sck_oe low in slave mode", sck_oe, 0);
    xfer_len_m1 = 3'(nb - 1);
    pulse_start();
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 so_oe driven while selected", so_oe, 1);
    chk("R6 sck_oe low while selected", sck_oe, 0);
    total = 0; cap = '0;
    for (int b = 0; b < nb; b++) begin
      for (int k = 0; k < 8; k++) begin
        if (abort_bits >= 0 && total == abort_bits) break;
        sck_in = 1'b0; si = stx[b][7 - k];
        repeat (5) @(negedge clk);
        cap = {cap[6:0], so};
        sck_in = 1'b1;
        repeat (5) @(negedge clk);
        total++;
        if (k == 7) got[b] = cap;
      end
    end
    if (abort_bits >= 0) begin
      cs_n = 1'b1;
      repeat (6) @(negedge clk);
      chk("R8 abort_err set", abort_err, 1);
      chk("R8 busy cleared", busy, 0);
      chk("R8 done stays low", done, 0);
      chk("R7 so_oe floats after deselect", so_oe, 0);
      chk("R6 byte shifted out", got[0], mtx[0]);
      get_slot(0, v);
      chk("R8 completed byte kept", v, stx[0]);
      get_slot(1, v);
      chk("R8 partial slot unchanged", v, mtx[1]);
    end else begin
      repeat (6) @(negedge clk);
      chk("R2 slave done", done, 1);
      chk("R2 slave busy clear", busy, 0);
      for (int i = 0; i < nb; i++) begin
        chk("R6 slave MSB-first on so", got[i], mtx[i]);
        get_slot(i, v);
        chk("R6 slave sampled byte stored", v, stx[i]);
      end
      cs_n = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_master(3, 8'h96, 1'b0);
    t_master(2, 8'h3C, 1'b1);
    t_master(8, 8'hA5, 1'b0);
    t_master(1, 8'h0F, 1'b0);
    t_slave(2, 8'h71, -1);
    t_slave(3, 8'h2B, 11);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule